// File: doc/BRIEF.md
# Hardwired Event Counter Bank

This block holds the programmable hardware event counters of a processor core's machine-mode counter space. Every clock cycle it receives a vector of one-bit event pulses from the pipeline (loads, stores, branches, compressed instructions, multiply and divide wait cycles and similar), plus a decode-completion strobe with two instruction-kind flags for pointer-signing and pointer-authentication instructions. Each implemented counter owns one event ID. It counts that event and no other, and the choice cannot be changed at run time.

Software reaches the bank through a 12-bit CSR address with a combinational read port and a single-cycle write port. A counter is `CNT_W` bits wide, 40 by default. Its lower 32 bits sit at `0xB00 + N` and its upper bits at `0xB80 + N`. The selector register for counter N sits at `0x320 + N` and reads back a constant with only bit N set. By default counters 3 to 14 exist (`CNT_NUM = 12`). All other slots of the space read as zero and ignore writes.

Top module: `hpm_event_bank`

## Requirements
- R1: After reset every implemented counter reads zero in both halves.
- R2: For N in 3..12, counter N rises by exactly one at each clock edge where `evt_i[N]` is 1, and holds when it is 0. Bits 0..2 and 13..31 of `evt_i` change no counter.
- R3: Counter 13 rises by one at each edge where `id_done_i` and `sign_kind_i` are both 1. Counter 14 does the same for `id_done_i` with `auth_kind_i`. With `id_done_i` at 0 neither flag changes anything.
- R4: Reading `0xB00 + N` returns counter bits [31:0]. Reading `0xB80 + N` returns bits [CNT_W-1:32], zero-extended to 32 bits.
- R5: A counter whose value is all ones becomes zero on its next event.
- R6: A write to `0xB00 + N` replaces bits [31:0]. A write to `0xB80 + N` replaces bits [CNT_W-1:32] with the low CNT_W-32 bits of the write data, and the rest of the data is dropped. Both results are readable from the next cycle.
- R7: A write to either half takes precedence over an event in the same cycle: no increment happens, and the other half keeps its value.
- R8: For N in 3..31, reading `0x320 + N` returns `1 << N` when counter N is implemented and 0 otherwise. Writes to these addresses change nothing.
- R9: Counter addresses with N in 0..2 or N above the implemented range read zero and ignore writes. Any address outside the three windows reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses indexed by event ID |
| id_done_i | input | 1 | Instruction completes in decode this cycle |
| sign_kind_i | input | 1 | Completing instruction is a pointer-signing instruction |
| auth_kind_i | input | 1 | Completing instruction is a pointer-authentication instruction |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for `csr_addr_i` |

## Verification
Single-bit bursts on one event line show that each counter reacts to its own ID alone. Raising the unused and pointer-authentication event bits without the completion strobe shows that those lines are gated or ignored. Preloading a counter to all ones and to chosen values, then pulsing its event in the same cycle as a write, separates wrap-around, half replacement and write precedence. Long random mixes of events with occasional writes to live and dead addresses then catch cross-talk between slots and misrouted write decodes.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

   localparam int unsigned HPM_SLOTS   = 32;
   localparam int unsigned HPM_FIRST   = 3;
   localparam int unsigned HPM_ADDR_W  = 12;
   localparam int unsigned HPM_DATA_W  = 32;
   localparam int unsigned HPM_IDX_W   = $clog2(HPM_SLOTS);
   localparam int unsigned HPM_PAGE_W  = HPM_ADDR_W - HPM_IDX_W;

   localparam logic [HPM_PAGE_W-1:0] PAGE_CNT_LO = 7'h58;
   localparam logic [HPM_PAGE_W-1:0] PAGE_CNT_HI = 7'h5C;
   localparam logic [HPM_PAGE_W-1:0] PAGE_SEL    = 7'h19;

   localparam int unsigned EVT_SIGN = 13;
   localparam int unsigned EVT_AUTH = 14;

   typedef enum logic [1:0] {
      SPACE_NONE,
      SPACE_LO,
      SPACE_HI,
      SPACE_SEL
   } csr_space_e;

   typedef struct packed {
      csr_space_e            space;
      logic [HPM_IDX_W-1:0]  idx;
   } csr_dec_t;

   function automatic csr_dec_t decode_addr(input logic [HPM_ADDR_W-1:0] a);
      csr_dec_t d;
      d.idx = a[HPM_IDX_W-1:0];
      unique case (a[HPM_ADDR_W-1:HPM_IDX_W])
         PAGE_CNT_LO: d.space = SPACE_LO;
         PAGE_CNT_HI: d.space = SPACE_HI;
         PAGE_SEL:    d.space = SPACE_SEL;
         default:     d.space = SPACE_NONE;
      endcase
      return d;
   endfunction

   function automatic logic [HPM_DATA_W-1:0] onehot_sel(input int unsigned id);
      return HPM_DATA_W'(1) << id;
   endfunction

   function automatic logic slot_live(input logic [HPM_IDX_W-1:0] idx,
                                      input int unsigned cnt_num);
      int unsigned n;
      n = {{(32-HPM_IDX_W){1'b0}}, idx};
      return (n >= HPM_FIRST) && (n < HPM_FIRST + cnt_num);
   endfunction

endpackage

// File: rtl/hpm_evt_route.sv
module hpm_evt_route
   import hpm_pkg::*;
#(
   parameter int unsigned CNT_NUM = 12
) (
   input  logic [HPM_SLOTS-1:0] evt_i,
   input  logic                 id_done_i,
   input  logic                 sign_kind_i,
   input  logic                 auth_kind_i,
   output logic [HPM_SLOTS-1:0] inc_o
);

   logic [HPM_SLOTS-1:0] src;

   always_comb begin
      src = evt_i;
      src[HPM_FIRST-1:0] = '0;
      src[EVT_SIGN] = id_done_i & sign_kind_i;
      src[EVT_AUTH] = id_done_i & auth_kind_i;
   end

   for (genvar i = 0; i < HPM_SLOTS; i++) begin : g_slot
      if (i >= HPM_FIRST && i < HPM_FIRST + CNT_NUM) begin : g_on
         logic [HPM_SLOTS-1:0] sel;
         assign sel      = onehot_sel(i);
         assign inc_o[i] = |(src & sel);
      end else begin : g_off
         assign inc_o[i] = 1'b0;
      end
   end

   logic unused_src;
   assign unused_src = ^src;

endmodule

// File: rtl/hpm_counter.sv
module hpm_counter
   import hpm_pkg::*;
#(
   parameter int unsigned CNT_W = 40
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  inc_i,
   input  logic                  wr_lo_i,
   input  logic                  wr_hi_i,
   input  logic [HPM_DATA_W-1:0] wdata_i,
   output logic [CNT_W-1:0]      cnt_o
);

   localparam int unsigned HI_W = CNT_W - HPM_DATA_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [HI_W-1:0]  hi_in;

   if (HI_W == HPM_DATA_W) begin : g_full_hi
      assign hi_in = wdata_i;
   end else begin : g_part_hi
      assign hi_in = wdata_i[HI_W-1:0];
      logic unused_wd;
      assign unused_wd = ^wdata_i[HPM_DATA_W-1:HI_W];
   end

   always_comb begin
      cnt_d = cnt_q;
      if (wr_lo_i) begin
         cnt_d[HPM_DATA_W-1:0] = wdata_i;
      end else if (wr_hi_i) begin
         cnt_d[CNT_W-1:HPM_DATA_W] = hi_in;
      end else if (inc_i) begin
         cnt_d = cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/hpm_csr_read.sv
module hpm_csr_read
   import hpm_pkg::*;
#(
   parameter int unsigned CNT_NUM = 12,
   parameter int unsigned CNT_W   = 40
) (
   input  csr_dec_t                          dec_i,
   input  logic [HPM_SLOTS-1:0][CNT_W-1:0]   cnt_all_i,
   output logic [HPM_DATA_W-1:0]             rdata_o
);

   logic [CNT_W-1:0] pick;
   logic             live;

   assign pick = cnt_all_i[dec_i.idx];
   assign live = slot_live(dec_i.idx, CNT_NUM);

   always_comb begin
      rdata_o = '0;
      unique case (dec_i.space)
         SPACE_LO:  if (live) rdata_o = pick[HPM_DATA_W-1:0];
         SPACE_HI:  if (live) rdata_o = HPM_DATA_W'(pick[CNT_W-1:HPM_DATA_W]);
         SPACE_SEL: if (live) rdata_o = onehot_sel({{(32-HPM_IDX_W){1'b0}}, dec_i.idx});
         default:   rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/hpm_event_bank.sv
module hpm_event_bank
   import hpm_pkg::*;
#(
   parameter int unsigned CNT_NUM = 12,
   parameter int unsigned CNT_W   = 40
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [HPM_SLOTS-1:0]  evt_i,
   input  logic                  id_done_i,
   input  logic                  sign_kind_i,
   input  logic                  auth_kind_i,
   input  logic [HPM_ADDR_W-1:0] csr_addr_i,
   input  logic                  csr_we_i,
   input  logic [HPM_DATA_W-1:0] csr_wdata_i,
   output logic [HPM_DATA_W-1:0] csr_rdata_o
);

   if (CNT_W <= HPM_DATA_W || CNT_W > 2 * HPM_DATA_W) begin : g_bad_width
      $error("hpm_event_bank: CNT_W must lie in 33..64");
   end
   if (CNT_NUM < 1 || CNT_NUM > HPM_SLOTS - HPM_FIRST) begin : g_bad_num
      $error("hpm_event_bank: CNT_NUM must lie in 1..29");
   end

   csr_dec_t                        dec;
   logic [HPM_SLOTS-1:0]            inc;
   logic [HPM_SLOTS-1:0]            wr_lo;
   logic [HPM_SLOTS-1:0]            wr_hi;
   logic [HPM_SLOTS-1:0][CNT_W-1:0] cnt_all;

   assign dec = decode_addr(csr_addr_i);

   hpm_evt_route #(.CNT_NUM(CNT_NUM)) u_route (
      .evt_i       (evt_i),
      .id_done_i   (id_done_i),
      .sign_kind_i (sign_kind_i),
      .auth_kind_i (auth_kind_i),
      .inc_o       (inc)
   );

   for (genvar i = 0; i < HPM_SLOTS; i++) begin : g_cnt
      if (i >= HPM_FIRST && i < HPM_FIRST + CNT_NUM) begin : g_live
         assign wr_lo[i] = csr_we_i && (dec.space == SPACE_LO)
                           && (dec.idx == HPM_IDX_W'(i));
         assign wr_hi[i] = csr_we_i && (dec.space == SPACE_HI)
                           && (dec.idx == HPM_IDX_W'(i));
         hpm_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .inc_i   (inc[i]),
            .wr_lo_i (wr_lo[i]),
            .wr_hi_i (wr_hi[i]),
            .wdata_i (csr_wdata_i),
            .cnt_o   (cnt_all[i])
         );
      end else begin : g_dead
         assign wr_lo[i]   = 1'b0;
         assign wr_hi[i]   = 1'b0;
         assign cnt_all[i] = '0;
      end
   end

   hpm_csr_read #(.CNT_NUM(CNT_NUM), .CNT_W(CNT_W)) u_read (
      .dec_i     (dec),
      .cnt_all_i (cnt_all),
      .rdata_o   (csr_rdata_o)
   );

endmodule

// File: rtl/hpm_event_bank_chk.sv
module hpm_event_bank_chk
   import hpm_pkg::*;
#(
   parameter int unsigned CNT_NUM = 12,
   parameter int unsigned CNT_W   = 40
) (
   input logic                            clk_i,
   input logic                            rst_ni,
   input logic                            id_done_i,
   input logic [HPM_ADDR_W-1:0]           csr_addr_i,
   input logic [HPM_DATA_W-1:0]           csr_wdata_i,
   input logic [HPM_DATA_W-1:0]           csr_rdata_o,
   input logic [HPM_SLOTS-1:0]            inc,
   input logic [HPM_SLOTS-1:0]            wr_lo,
   input logic [HPM_SLOTS-1:0]            wr_hi,
   input logic [HPM_SLOTS-1:0][CNT_W-1:0] cnt_all
);

   localparam int unsigned HI_W = CNT_W - HPM_DATA_W;

   logic [HPM_PAGE_W-1:0] page;
   logic [HPM_IDX_W-1:0]  idx;
   assign page = csr_addr_i[HPM_ADDR_W-1:HPM_IDX_W];
   assign idx  = csr_addr_i[HPM_IDX_W-1:0];

   for (genvar i = HPM_FIRST; i < HPM_FIRST + CNT_NUM; i++) begin : g_c
      p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (inc[i] && !wr_lo[i] && !wr_hi[i]) |=> cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1));
      p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!inc[i] && !wr_lo[i] && !wr_hi[i]) |=> $stable(cnt_all[i]));
      p_wr_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         wr_lo[i] |=> (cnt_all[i][HPM_DATA_W-1:0] == $past(csr_wdata_i))
                   && $stable(cnt_all[i][CNT_W-1:HPM_DATA_W]));
      p_wr_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         wr_hi[i] |=> (cnt_all[i][CNT_W-1:HPM_DATA_W] == $past(csr_wdata_i[HI_W-1:0]))
                   && $stable(cnt_all[i][HPM_DATA_W-1:0]));
   end

   if (CNT_NUM >= EVT_AUTH - HPM_FIRST + 1) begin : g_gate
      p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !id_done_i |-> !inc[EVT_SIGN] && !inc[EVT_AUTH]);
   end

   p_sel_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (page == PAGE_SEL) |-> $onehot0(csr_rdata_o));
   p_sel_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (page == PAGE_SEL && slot_live(idx, CNT_NUM)) |-> csr_rdata_o == (HPM_DATA_W'(1) << idx));
   p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (page != PAGE_SEL && page != PAGE_CNT_LO && page != PAGE_CNT_HI) |-> csr_rdata_o == '0);
   p_dead_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((page == PAGE_CNT_LO || page == PAGE_CNT_HI) && !slot_live(idx, CNT_NUM))
      |-> csr_rdata_o == '0);
   p_hi_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (page == PAGE_CNT_HI) |-> csr_rdata_o[HPM_DATA_W-1:HI_W] == '0);

endmodule

bind hpm_event_bank hpm_event_bank_chk #(.CNT_NUM(CNT_NUM), .CNT_W(CNT_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .id_done_i   (id_done_i),
   .csr_addr_i  (csr_addr_i),
   .csr_wdata_i (csr_wdata_i),
   .csr_rdata_o (csr_rdata_o),
   .inc         (inc),
   .wr_lo       (wr_lo),
   .wr_hi       (wr_hi),
   .cnt_all     (cnt_all)
);

// File: tb/sim_hpm_event_bank.sv
`timescale 1ns/1ps
module sim_hpm_event_bank;

   localparam int NCNT  = 12;
   localparam int W     = 40;
   localparam int FIRST = 3;
   localparam int LAST  = FIRST + NCNT - 1;
   localparam logic [63:0] MASK = (64'd1 << W) - 64'd1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt = '0;
   logic        done = 1'b0, sgn = 1'b0, ath = 1'b0;
   logic [11:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;
   logic [63:0] mdl [32];

   always #5 clk = ~clk;

   hpm_event_bank u0 (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .id_done_i(done),
      .sign_kind_i(sgn), .auth_kind_i(ath), .csr_addr_i(addr),
      .csr_we_i(we), .csr_wdata_i(wdata), .csr_rdata_o(rdata)
   );

   function automatic bit exp_inc(int i, logic [31:0] e, logic d, logic s, logic a);
      if (i == 13) return d & s;
      if (i == 14) return d & a;
      return e[i];
   endfunction

   function automatic logic [31:0] exp_sel(int n);
      return (n >= FIRST && n <= LAST) ? (32'd1 << n) : 32'd0;
   endfunction

   task automatic cyc(input logic [31:0] e, input logic d, s, a,
                      input logic w, input logic [11:0] ad, input logic [31:0] wd);
      @(negedge clk);
      evt = e; done = d; sgn = s; ath = a; we = w; addr = ad; wdata = wd;
      @(posedge clk);
      for (int i = FIRST; i <= LAST; i++) begin
         if (w && ad == (12'hB00 + 12'(i)))
            mdl[i] = {mdl[i][63:32], wd} & MASK;
         else if (w && ad == (12'hB80 + 12'(i)))
            mdl[i] = {wd, mdl[i][31:0]} & MASK;
         else if (exp_inc(i, e, d, s, a))
            mdl[i] = (mdl[i] + 64'd1) & MASK;
      end
   endtask

   task automatic rd(input logic [11:0] ad, input logic [31:0] exp, input string tag);
      @(negedge clk);
      evt = '0; done = 0; sgn = 0; ath = 0; we = 0; wdata = '0; addr = ad;
      #1;
      nchk++;
      if (rdata !== exp) begin
         nfail++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, ad, rdata, exp);
      end
   endtask

   task automatic chk_cnt(input int i, input string tag);
      rd(12'hB00 + 12'(i), mdl[i][31:0], tag);
      rd(12'hB80 + 12'(i), mdl[i][63:32], tag);
   endtask

   task automatic chk_all(input string tag);
      for (int i = FIRST; i <= LAST; i++) chk_cnt(i, tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 32; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk_all("R1 reset");

      // R8: selector constants and write immunity
      for (int n = FIRST; n < 32; n++) rd(12'h320 + 12'(n), exp_sel(n), "R8 selector");
      cyc('0, 0, 0, 0, 1, 12'h325, 32'h0);
      cyc('0, 0, 0, 0, 1, 12'h32F, 32'hFFFF_FFFF);
      rd(12'h325, 32'h20, "R8 selector after write");
      rd(12'h32F, 32'h0, "R8 dead selector after write");

      // R2: single-event bursts
      repeat (5) cyc(32'h8, 0, 0, 0, 0, 12'h0, 0);
      repeat (3) cyc(32'h1000, 0, 0, 0, 0, 12'h0, 0);
      chk_all("R2 single event");
      // R2: ignored event bits, R3: gated lines without done
      repeat (4) cyc(32'hFFFF_E007, 0, 1, 1, 0, 12'h0, 0);
      chk_all("R2 ignored bits");

      // R3: sign/auth completion
      repeat (3) cyc('0, 1, 1, 0, 0, 12'h0, 0);
      repeat (2) cyc('0, 1, 0, 1, 0, 12'h0, 0);
      cyc('0, 1, 1, 1, 0, 12'h0, 0);
      cyc('0, 1, 0, 0, 0, 12'h0, 0);
      chk_cnt(13, "R3 sign count");
      chk_cnt(14, "R3 auth count");

      // R6 / R4: write halves, upper bits of high data dropped
      cyc('0, 0, 0, 0, 1, 12'hB05, 32'hFFFF_FFFF);
      cyc('0, 0, 0, 0, 1, 12'hB85, 32'hFFFF_FFFF);
      rd(12'hB85, 32'h0000_00FF, "R6 high half width");
      rd(12'hB05, 32'hFFFF_FFFF, "R4 low half");
      // R5: wrap
      cyc(32'h20, 0, 0, 0, 0, 12'h0, 0);
      rd(12'hB05, 32'h0, "R5 wrap low");
      rd(12'hB85, 32'h0, "R5 wrap high");

      // R7: write beats increment
      cyc(32'h10, 0, 0, 0, 1, 12'hB04, 32'h0000_1234);
      rd(12'hB04, 32'h0000_1234, "R7 low write vs event");
      cyc(32'h10, 0, 0, 0, 1, 12'hB84, 32'h0000_00A5);
      rd(12'hB84, 32'h0000_00A5, "R7 high write vs event");
      rd(12'hB04, 32'h0000_1234, "R7 other half kept");
      chk_all("R7 model");

      // R9: dead counters and unmapped space
      cyc('1, 1, 1, 1, 1, 12'hB0F, 32'h5555_5555);
      cyc('0, 0, 0, 0, 1, 12'hB8F, 32'h5555_5555);
      cyc('0, 0, 0, 0, 1, 12'hB01, 32'h5555_5555);
      rd(12'hB0F, 32'h0, "R9 dead low");
      rd(12'hB8F, 32'h0, "R9 dead high");
      rd(12'hB01, 32'h0, "R9 slot one");
      rd(12'hB1F, 32'h0, "R9 top slot");
      rd(12'h000, 32'h0, "R9 unmapped");
      rd(12'hC05, 32'h0, "R9 unmapped");
      chk_all("R9 no side effect");

      // Random mix: R2 R3 R6 R7
      for (int k = 0; k < 4000; k++) begin
         logic [31:0] e;
         logic [11:0] ad;
         logic        w;
         e  = $urandom;
         w  = ($urandom % 12) == 0;
         ad = (($urandom % 2) ? 12'hB80 : 12'hB00) + 12'($urandom % 18);
         cyc(e, 1'($urandom), 1'($urandom), 1'($urandom), w, ad, $urandom);
         if (k % 250 == 249) chk_cnt(FIRST + int'($urandom % NCNT), "R2 R3 random");
      end
      chk_all("R6 R7 random final");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end

endmodule